// File: doc/BRIEF.md
# External Bus Interface Controller

This block connects an internal bus, which carries one request at a time, to an external parallel bus with strobes. A request holds a halfword address, a read or write flag, a two-bit byte mask and 16 bits of write data. The internal side offers the request with a ready/valid handshake. The controller then runs exactly one external cycle. For a read it returns the captured data together with a one-clock done pulse. The external bus clock is the block clock.

On the external side the block drives:
- a halfword address;
- two active-low chip selects, one for each half of the address space;
- active-low read and write strobes;
- active-low high-byte and low-byte enables;
- an enable for the bus clock pad driver.

The 16-bit data bus is bidirectional. The block drives it only while a write strobe is low, and only on the lanes being written. Every external cycle contains one forced wait state, so the shortest cycle is two bus clocks. An active-low wait input can stretch the cycle further. Between two cycles the bus always returns to a quiet state, so that a read and a write never fight over the data lines.

Top module: `xbus_bridge`

## Requirements
- R1: After reset, and whenever no cycle is active, the read and write strobes, both chip selects and both byte enables are high. The bus clock enable is low and ready is high. The data bus is not driven, so any value the external side places on it during a read reaches the captured data unchanged.
- R2: A read cycle drives the read strobe low and keeps the write strobe high. It drives the byte enable low for each lane whose mask bit is set and leaves the other enable high. Byte enable bit 1 and mask bit 1 belong to data bits 15:8. Bit 0 of each belongs to data bits 7:0.
- R3: A write cycle drives the write strobe low and keeps the read strobe high. The byte enables follow the mask as in R2. For the whole time the write strobe is low, each masked lane carries the matching byte of the write data.
- R4: The chip selects are active low. Chip select bit 0 is low when request address bit 30 is 0, and chip select bit 1 is low when it is 1. Exactly one is low during an active cycle.
- R5: When the wait input stays high, the strobe is low for exactly 2 clocks.
- R6: The wait input is sampled on each clock edge that ends a wait state. Each low sample adds one more wait state, so the strobe stays low for 2 + N clocks, where N is the number of low samples.
- R7: Read data is latched on the last edge before the read strobe rises. A lane whose mask bit is clear returns 0, and a write cycle returns 0 on all lanes.
- R8: The done output is high for exactly one clock: the first clock after the strobe rises. The returned data is valid in that clock.
- R9: Ready is high only in the idle state. A request held valid during a cycle is not taken until the cycle has ended. The strobes then stay high for 2 clocks before the next cycle starts.
- R10: The address output equals request address bits 30:1, and is valid from the first clock of the strobe. The address, chip selects and byte enables do not change while the strobe is low.
- R11: The bus clock enable is high exactly in the clocks in which a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the external bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Internal request offered |
| req_ready_o | output | 1 | Controller can take a request |
| req_addr_i | input | 30 | Halfword address, bits 30:1 |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mask_i | input | 2 | Byte lanes taking part (bit 1 = high byte) |
| req_wdata_i | input | 16 | Write data |
| rsp_done_o | output | 1 | One-clock completion pulse |
| rsp_rdata_o | output | 16 | Captured read data |
| xa_o | output | 30 | External address |
| xcs_n_o | output | 2 | Active-low chip selects |
| xrd_n_o | output | 1 | Active-low read strobe |
| xwr_n_o | output | 1 | Active-low write strobe |
| xbe_n_o | output | 2 | Active-low byte enables (bit 1 = high byte) |
| xwait_n_i | input | 1 | Active-low wait request |
| xd_io | inout | 16 | External data bus |
| xclk_en_o | output | 1 | Bus clock pad driver enable |

## Verification
Two events can land on the same edge. The first pair is the release of the wait input and the read-data capture: the wait input is sampled high on the very edge that latches the read data. The bench drives this case with wait sequences of several lengths. It judges the outcome from the strobe length and the value returned. The second case holds a new request valid across a whole cycle, with its fields changed halfway through. The bench checks that the running cycle's address stays fixed, that the request is taken only after the done clock plus one idle clock, and that the next cycle carries the new address.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } xbus_state_e;
endpackage

// File: rtl/xbus_rst_sync.sv
module xbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire_i,
  input  logic        wait_n_i,
  output logic        ready_o,
  output logic        strobe_o,
  output logic        capture_o,
  output logic        done_o
);
  xbus_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (fire_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_WAIT;
      ST_WAIT: if (wait_n_i) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign strobe_o  = (state_q == ST_ADDR) || (state_q == ST_WAIT);
  assign capture_o = (state_q == ST_WAIT) && wait_n_i;
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [LANE_W-1:0] wdata_i,
  input  logic              write_i,
  input  logic              strobe_i,
  input  logic              capture_i,
  output logic              be_n_o,
  output logic [LANE_W-1:0] rdata_o,
  inout  wire  [LANE_W-1:0] pad_io
);
  logic              en_q;
  logic [LANE_W-1:0] wdata_q;
  logic [LANE_W-1:0] rdata_q, rdata_d;
  logic              drive;

  always_comb begin
    rdata_d = rdata_q;
    if (capture_i) rdata_d = (en_q && !write_i) ? pad_io : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (load_i) begin
        en_q    <= en_i;
        wdata_q <= wdata_i;
      end
      rdata_q <= rdata_d;
    end
  end

  assign drive   = strobe_i && write_i && en_q;
  assign pad_io  = drive ? wdata_q : {LANE_W{1'bz}};
  assign be_n_o  = !(strobe_i && en_q);
  assign rdata_o = rdata_q;
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge #(
  parameter int ADDR_W = 31,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [ADDR_W-1:1]      req_addr_i,
  input  logic                   req_write_i,
  input  logic [DATA_W/LANE_W-1:0] req_mask_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic                   rsp_done_o,
  output logic [DATA_W-1:0]      rsp_rdata_o,
  output logic [ADDR_W-1:1]      xa_o,
  output logic [1:0]             xcs_n_o,
  output logic                   xrd_n_o,
  output logic                   xwr_n_o,
  output logic [DATA_W/LANE_W-1:0] xbe_n_o,
  input  logic                   xwait_n_i,
  inout  wire  [DATA_W-1:0]      xd_io,
  output logic                   xclk_en_o
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int CS_BIT = ADDR_W - 1;

  logic              srst_n;
  logic              accept;
  logic              strobe_on;
  logic              capture;
  logic [ADDR_W-1:1] addr_q;
  logic              write_q;

  xbus_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  xbus_seq u_seq (
    .clk       (clk),
    .rst_n     (srst_n),
    .fire_i    (accept),
    .wait_n_i  (xwait_n_i),
    .ready_o   (req_ready_o),
    .strobe_o  (strobe_on),
    .capture_o (capture),
    .done_o    (rsp_done_o)
  );

  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      write_q <= req_write_i;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xbus_lane #(.LANE_W(LANE_W)) u_lane (
      .clk       (clk),
      .rst_n     (srst_n),
      .load_i    (accept),
      .en_i      (req_mask_i[l]),
      .wdata_i   (req_wdata_i[l*LANE_W +: LANE_W]),
      .write_i   (write_q),
      .strobe_i  (strobe_on),
      .capture_i (capture),
      .be_n_o    (xbe_n_o[l]),
      .rdata_o   (rsp_rdata_o[l*LANE_W +: LANE_W]),
      .pad_io    (xd_io[l*LANE_W +: LANE_W])
    );
  end

  assign xa_o      = addr_q;
  assign xcs_n_o   = !strobe_on      ? 2'b11 :
                     addr_q[CS_BIT]  ? 2'b01 : 2'b10;
  assign xrd_n_o   = !(strobe_on && !write_q);
  assign xwr_n_o   = !(strobe_on && write_q);
  assign xclk_en_o = strobe_on;
endmodule

// File: rtl/xbus_bridge_chk.sv
module xbus_bridge_chk #(
  parameter int ADDR_W = 31,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready_o,
  input logic              rsp_done_o,
  input logic [ADDR_W-1:1] xa_o,
  input logic [1:0]        xcs_n_o,
  input logic              xrd_n_o,
  input logic              xwr_n_o,
  input logic [LANES-1:0]  xbe_n_o,
  input logic              xwait_n_i,
  input logic              xclk_en_o
);
  logic       strb_n;
  logic [1:0] run_q;

  assign strb_n = xrd_n_o && xwr_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= 2'd0;
    else if (strb_n)     run_q <= 2'd0;
    else if (run_q != 2'd3) run_q <= run_q + 2'd1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb_n |-> (xcs_n_o == 2'b11) && (&xbe_n_o) && !xclk_en_o);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!xrd_n_o && !xwr_n_o));

  p_one_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_n |-> $countones(~xcs_n_o) == 1);

  p_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_n) |=> !strb_n);

  p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_n && run_q != 2'd0 && !xwait_n_i) |=> !strb_n);

  p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_n) |-> rsp_done_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done_o |=> !rsp_done_o);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> strb_n && !rsp_done_o);

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_n && run_q != 2'd0) |-> $stable(xa_o) && $stable(xcs_n_o) && $stable(xbe_n_o));

  p_clk_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xclk_en_o == !strb_n);
endmodule

bind xbus_bridge xbus_bridge_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W/LANE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready_o (req_ready_o),
  .rsp_done_o  (rsp_done_o),
  .xa_o        (xa_o),
  .xcs_n_o     (xcs_n_o),
  .xrd_n_o     (xrd_n_o),
  .xwr_n_o     (xwr_n_o),
  .xbe_n_o     (xbe_n_o),
  .xwait_n_i   (xwait_n_i),
  .xclk_en_o   (xclk_en_o)
);

// File: tb/sim_xbus_bridge.sv
`timescale 1ns/1ps
module sim_xbus_bridge;
  typedef struct packed {
    logic [30:0] addr;
    logic        wr;
    logic [1:0]  mask;
    logic [15:0] wdata;
    logic [15:0] ext;
    logic [3:0]  nw;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{31'h0000_1000, 1'b0, 2'b11, 16'h0000, 16'hA55A, 4'd0},
    '{31'h4000_2002, 1'b0, 2'b01, 16'h0000, 16'h1234, 4'd1},
    '{31'h0000_0FFE, 1'b0, 2'b10, 16'h0000, 16'hBEEF, 4'd3},
    '{31'h7FFF_FFFE, 1'b1, 2'b11, 16'hC0DE, 16'h0000, 4'd0},
    '{31'h0000_0010, 1'b1, 2'b01, 16'h00AB, 16'h0000, 4'd2},
    '{31'h4000_0000, 1'b1, 2'b10, 16'hCD00, 16'h0000, 4'd5},
    '{31'h2AAA_AAAA, 1'b0, 2'b11, 16'h0000, 16'h0F0F, 4'd7},
    '{31'h5555_5554, 1'b1, 2'b11, 16'hFFFF, 16'h0000, 4'd1}
  };

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [30:1] req_addr;
  logic [1:0]  req_mask;
  logic [15:0] req_wdata;
  logic        done;
  logic [15:0] rdata;
  logic [30:1] xa;
  logic [1:0]  xcs_n, xbe_n;
  logic        xrd_n, xwr_n, xwait_n, xclk_en;
  wire  [15:0] xd;
  logic        ext_oe;
  logic [15:0] ext_d;
  int          n_chk, n_fail;
  bit          finished;

  assign xd = ext_oe ? ext_d : 16'hzzzz;

  xbus_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write),
    .req_mask_i(req_mask), .req_wdata_i(req_wdata),
    .rsp_done_o(done), .rsp_rdata_o(rdata),
    .xa_o(xa), .xcs_n_o(xcs_n), .xrd_n_o(xrd_n), .xwr_n_o(xwr_n),
    .xbe_n_o(xbe_n), .xwait_n_i(xwait_n), .xd_io(xd), .xclk_en_o(xclk_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rdata(input vec_t v);
    logic [15:0] r;
    r = 16'h0000;
    if (!v.wr) begin
      if (v.mask[1]) r[15:8] = v.ext[15:8];
      if (v.mask[0]) r[7:0]  = v.ext[7:0];
    end
    return r;
  endfunction

  task automatic run_txn(input vec_t v);
    int len;
    logic [1:0] cs_exp;
    cs_exp = v.addr[30] ? 2'b01 : 2'b10;
    @(negedge clk);
    req_valid = 1'b1; req_addr = v.addr[30:1]; req_write = v.wr;
    req_mask = v.mask; req_wdata = v.wdata;
    chk(req_ready == 1'b1, "R9 ready in idle", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    len = 0;
    while (!(xrd_n && xwr_n) && len < 40) begin
      len++;
      if (len == 1) begin
        chk(xrd_n == v.wr, "R2 read strobe", {31'd0, xrd_n}, {31'd0, v.wr});
        chk(xwr_n == !v.wr, "R3 write strobe", {31'd0, xwr_n}, {31'd0, !v.wr});
        chk(xbe_n == ~v.mask, "R2 byte enables", {30'd0, xbe_n}, {30'd0, ~v.mask});
        chk(xcs_n == cs_exp, "R4 chip select", {30'd0, xcs_n}, {30'd0, cs_exp});
        chk(xa == v.addr[30:1], "R10 address", {2'd0, xa}, {2'd0, v.addr[30:1]});
        chk(req_ready == 1'b0, "R9 busy", {31'd0, req_ready}, 32'd0);
      end
      chk(xclk_en == 1'b1, "R11 clock enable", {31'd0, xclk_en}, 32'd1);
      if (v.wr) begin
        if (v.mask[1]) chk(xd[15:8] == v.wdata[15:8], "R3 high lane", {24'd0, xd[15:8]}, {24'd0, v.wdata[15:8]});
        if (v.mask[0]) chk(xd[7:0] == v.wdata[7:0], "R3 low lane", {24'd0, xd[7:0]}, {24'd0, v.wdata[7:0]});
      end else begin
        ext_oe = 1'b1; ext_d = v.ext;
      end
      xwait_n = !(len >= 2 && len < 2 + int'(v.nw));
      @(negedge clk);
    end
    ext_oe = 1'b0; xwait_n = 1'b1;
    chk(len == 2 + int'(v.nw), (v.nw == 0) ? "R5 min length" : "R6 wait length", len, 2 + v.nw);
    chk(done == 1'b1, "R8 done after release", {31'd0, done}, 32'd1);
    chk(rdata == exp_rdata(v), "R7 read data", {16'd0, rdata}, {16'd0, exp_rdata(v)});
    chk(xclk_en == 1'b0, "R11 clock off", {31'd0, xclk_en}, 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one clock", {31'd0, done}, 32'd0);
    chk(req_ready == 1'b1, "R1 back to idle", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    int guard;
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    req_mask = 2'b00; req_wdata = '0; xwait_n = 1'b1; ext_oe = 1'b0; ext_d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(xrd_n && xwr_n, "R1 strobes idle", {30'd0, xrd_n, xwr_n}, 32'd3);
    chk(xcs_n == 2'b11 && xbe_n == 2'b11, "R1 selects idle", {28'd0, xcs_n, xbe_n}, 32'hF);
    chk(!xclk_en && req_ready && !done, "R1 clock/ready idle", {29'd0, xclk_en, req_ready, done}, 32'd2);

    for (int i = 0; i < NV; i++) run_txn(VECS[i]);

    // R9 / R10: request held valid across a cycle with fields changed mid-cycle
    @(negedge clk);
    req_valid = 1'b1; req_addr = 30'h0000_0123; req_write = 1'b1;
    req_mask = 2'b11; req_wdata = 16'h5A5A;
    @(negedge clk);
    req_addr = 30'h2000_0456;
    guard = 0;
    while (!(xrd_n && xwr_n) && guard < 20) begin
      guard++;
      chk(xa == 30'h0000_0123, "R10 address held", {2'd0, xa}, 32'h123);
      chk(req_ready == 1'b0, "R9 stall during cycle", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    guard = 0;
    while (xrd_n && xwr_n && guard < 20) begin
      guard++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(guard == 2, "R9 idle gap", guard, 32'd2);
    chk(xa == 30'h2000_0456, "R9 next request taken", {2'd0, xa}, 32'h2000_0456);
    chk(xcs_n == 2'b01, "R4 upper region select", {30'd0, xcs_n}, 32'd1);
    repeat (4) @(negedge clk);
    chk(xrd_n && xwr_n && req_ready, "R1 idle after handshake", {29'd0, xrd_n, xwr_n, req_ready}, 32'd7);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule